// File: doc/BRIEF.md
# Segmented ROM/RAM Bank Mapper

This block translates the addresses of an 8-bit CPU into physical memory addresses for a cartridge that shows a 4 KB window. A write to one control port carries a single byte. That byte selects ROM or RAM, names one of four destination segments and gives a 5-bit bank number. From then on, every bus access in the window is steered to an external ROM or RAM array. The block produces the physical address, one memory enable or the RAM write strobe, and a flag that says when the cartridge should drive the data bus.

ROM is switched in 1 KB slots. RAM is switched in 512-byte slots, and each RAM slot has a read window in the lower half of the cartridge window and a write window 0x800 above it. The mapper holds eight 512-byte region descriptors, so a RAM slot hides only the halves of the ROM slots it covers. A later ROM switch on a slot takes back both halves of that slot. The arrays themselves sit outside the block. The mapping state is cleared by a synchronous reset. After reset only the top ROM segment is mapped, to bank 0, so the reset vectors come from the first kilobyte of ROM.

Top module: `bank_mapper_top`

## Requirements
- R1: The mapping changes only on a clock edge where `bus_wr` is high, `bus_addr[12]` is 0 and `bus_addr[11:0]` equals 0x03F. Every other write leaves the mapping unchanged, including a write at 0x103F or at other offsets. A new mapping takes effect from the cycle after that edge.
- R2: In the control byte, bit 7 = 1 selects RAM and 0 selects ROM. Bits 6:5 give the destination segment s (0 to 3). Bits 4:0 give the bank number.
- R3: After a ROM switch to segment s with bank b, a read at window offsets s*0x400 to s*0x400+0x3FF asserts `rom_oe` with `rom_addr` = b*1024 + `bus_addr[9:0]`.
- R4: After a RAM switch to segment s with bank b, the following applies, with `ram_addr` = b*512 + `bus_addr[8:0]` in both cases. A read at offsets s*0x200 to +0x1FF asserts `ram_oe`. A write at offsets s*0x200+0x800 to +0x1FF asserts `ram_we`.
- R5: After reset, offsets 0xC00 to 0xFFF read ROM bank 0. Every other offset is unmapped.
- R6: A RAM switch replaces only the 512-byte halves it covers, and the other half of an affected ROM slot stays readable. A later ROM switch on that slot restores ROM on both halves.
- R7: These accesses assert no enable and do not drive the bus: a read from a RAM write window, a write to a ROM region, a write to a RAM read window, and any access to an unmapped region.
- R8: When `bus_addr[12]` is 0, no memory enable or write strobe is asserted.
- R9: `data_drive` is high exactly when `rom_oe` or `ram_oe` is high.
- R10: At most one of `rom_oe`, `ram_oe` and `ram_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | CPU address; bit 12 selects the cartridge window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_din | input | 8 | CPU write data (control byte) |
| rom_addr | output | 15 | Physical ROM address |
| ram_addr | output | 14 | Physical RAM address |
| rom_oe | output | 1 | ROM read enable |
| ram_oe | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write strobe |
| data_drive | output | 1 | Cartridge drives the data bus |

## Verification
The enables, the physical addresses and `data_drive` are combinational functions of the current access and the stored descriptors. The bench therefore samples them one time unit after it drives a probe at the falling edge, in the same cycle. A control write takes effect at the next rising edge. The bench releases the write after that edge and probes from the following falling edge, so every probe sees the mapping one edge after the switch. The sweep issues all 256 control bytes and probes all eight regions with both strobes after each one, checking against a model in the bench.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    localparam int BANK_W     = 5;
    localparam int SEG_W      = 2;
    localparam int REGION_W   = 3;
    localparam int REGION_CNT = 1 << REGION_W;
    localparam int WIN_W      = 12;
    localparam int ADDR_W     = WIN_W + 1;
    localparam int DATA_W     = 8;
    localparam int ROM_OFS_W  = WIN_W - SEG_W;
    localparam int RAM_OFS_W  = ROM_OFS_W - 1;
    localparam int ROM_AW     = BANK_W + ROM_OFS_W;
    localparam int RAM_AW     = BANK_W + RAM_OFS_W;
    localparam logic [WIN_W-1:0] CTRL_PORT = 12'h03F;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ROM    = 2'd1,
        SRC_RAM_RD = 2'd2,
        SRC_RAM_WR = 2'd3
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [BANK_W-1:0] bank;
    } region_t;

    typedef struct packed {
        logic              is_ram;
        logic [SEG_W-1:0]  seg;
        logic [BANK_W-1:0] bank;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.is_ram = b[DATA_W-1];
        c.seg    = b[DATA_W-2 -: SEG_W];
        c.bank   = b[BANK_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/bm_ctrl_decode.sv
module bm_ctrl_decode
    import bank_mapper_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic              upd,
    output ctrl_t             cmd
);
    always_comb begin
        upd = wr && !addr[ADDR_W-1] && (addr[WIN_W-1:0] == CTRL_PORT);
        cmd = unpack_ctrl(din);
    end
endmodule

// File: rtl/bm_region_table.sv
module bm_region_table
    import bank_mapper_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           upd,
    input  ctrl_t                          cmd,
    output region_t [REGION_CNT-1:0]       tab
);
    localparam int RAM_WR_BASE = REGION_CNT / 2;

    for (genvar r = 0; r < REGION_CNT; r++) begin : g_region
        localparam logic [SEG_W-1:0] ROM_SEG = SEG_W'(r / 2);
        localparam bit BOOT_ROM = (r >= REGION_CNT - 2);

        always_ff @(posedge clk) begin
            if (rst) begin
                tab[r].src  <= BOOT_ROM ? SRC_ROM : SRC_NONE;
                tab[r].bank <= '0;
            end else if (upd) begin
                if (!cmd.is_ram && cmd.seg == ROM_SEG) begin
                    tab[r].src  <= SRC_ROM;
                    tab[r].bank <= cmd.bank;
                end else if (cmd.is_ram && r < RAM_WR_BASE && 32'(cmd.seg) == r) begin
                    tab[r].src  <= SRC_RAM_RD;
                    tab[r].bank <= cmd.bank;
                end else if (cmd.is_ram && r >= RAM_WR_BASE && 32'(cmd.seg) + RAM_WR_BASE == r) begin
                    tab[r].src  <= SRC_RAM_WR;
                    tab[r].bank <= cmd.bank;
                end
            end
        end

        AST_ROM_SWITCH: assert property (@(posedge clk) disable iff (rst)
            (upd && !cmd.is_ram && cmd.seg == ROM_SEG)
            |=> (tab[r].src == SRC_ROM && tab[r].bank == $past(cmd.bank))); // R3
    end

    AST_BOOT_MAP: assert property (@(posedge clk)
        rst |=> (tab[REGION_CNT-1].src == SRC_ROM && tab[REGION_CNT-1].bank == '0
              && tab[REGION_CNT-2].src == SRC_ROM && tab[REGION_CNT-2].bank == '0
              && tab[0].src == SRC_NONE)); // R5
endmodule

// File: rtl/bm_access.sv
module bm_access
    import bank_mapper_pkg::*;
(
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      rd,
    input  logic                      wr,
    input  region_t [REGION_CNT-1:0]  tab,
    output logic [ROM_AW-1:0]         rom_addr,
    output logic [RAM_AW-1:0]         ram_addr,
    output logic                      rom_oe,
    output logic                      ram_oe,
    output logic                      ram_we,
    output logic                      data_drive
);
    logic                sel;
    logic [REGION_W-1:0] idx;
    region_t             d;

    always_comb begin
        sel        = addr[ADDR_W-1];
        idx        = addr[WIN_W-1 -: REGION_W];
        d          = tab[idx];
        rom_addr   = {d.bank, addr[ROM_OFS_W-1:0]};
        ram_addr   = {d.bank, addr[RAM_OFS_W-1:0]};
        rom_oe     = sel && rd && (d.src == SRC_ROM);
        ram_oe     = sel && rd && (d.src == SRC_RAM_RD);
        ram_we     = sel && wr && (d.src == SRC_RAM_WR);
        data_drive = sel && rd && (d.src inside {SRC_ROM, SRC_RAM_RD});
    end
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_din,
    output logic [14:0]       rom_addr,
    output logic [13:0]       ram_addr,
    output logic              rom_oe,
    output logic              ram_oe,
    output logic              ram_we,
    output logic              data_drive
);
    logic                     upd;
    ctrl_t                    cmd;
    region_t [REGION_CNT-1:0] tab;

    bm_ctrl_decode u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .din  (bus_din),
        .upd  (upd),
        .cmd  (cmd)
    );

    bm_region_table u_table (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .cmd  (cmd),
        .tab  (tab)
    );

    bm_access u_access (
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .tab        (tab),
        .rom_addr   (rom_addr),
        .ram_addr   (ram_addr),
        .rom_oe     (rom_oe),
        .ram_oe     (ram_oe),
        .ram_we     (ram_we),
        .data_drive (data_drive)
    );

    AST_HOLD_MAP: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_addr[12] && bus_addr[11:0] == CTRL_PORT) |=> $stable(tab)); // R1
    AST_NO_CART_LOW: assert property (@(posedge clk) disable iff (rst)
        !bus_addr[12] |-> !(rom_oe || ram_oe || ram_we)); // R8
    AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
        data_drive == (rom_oe || ram_oe)); // R9
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_oe, ram_oe, ram_we})); // R10
endmodule

// File: tb/bank_mapper_top_bench.sv
module bank_mapper_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [14:0] rom_addr;
    logic [13:0] ram_addr;
    logic        rom_oe, ram_oe, ram_we, data_drive;

    int n_cmp = 0;
    int n_bad = 0;
    int m_src [8];   // 0 none, 1 ROM, 2 RAM read, 3 RAM write
    int m_bank[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper_top u_bank_mapper_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_din(bus_din), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .rom_oe(rom_oe), .ram_oe(ram_oe),
        .ram_we(ram_we), .data_drive(data_drive)
    );

    task automatic model_reset();
        for (int r = 0; r < 8; r++) begin
            m_src[r]  = (r >= 6) ? 1 : 0;
            m_bank[r] = 0;
        end
    endtask

    task automatic model_switch(input int b);
        int seg, bank;
        seg  = (b / 32) % 4;
        bank = b % 32;
        if (b >= 128) begin
            m_src[seg] = 2;     m_bank[seg] = bank;
            m_src[seg+4] = 3;   m_bank[seg+4] = bank;
        end else begin
            m_src[2*seg] = 1;   m_bank[2*seg] = bank;
            m_src[2*seg+1] = 1; m_bank[2*seg+1] = bank;
        end
    endtask

    // write on the bus; updates the model only at the control port
    task automatic bus_write(input logic [12:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_din = v; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        if (a == 13'h003F) model_switch(int'(v));
    endtask

    // one access probe compared against the model, same cycle
    task automatic probe(input logic [12:0] a, input bit is_rd, input string tag);
        logic [3:0] ef, af;
        int r, exp_addr, act_addr;
        bit use_rom, use_ram;
        @(negedge clk);
        bus_addr = a; bus_rd = is_rd; bus_wr = !is_rd;
        #1;
        r = int'(a[11:9]);
        ef = 4'b0000; use_rom = 0; use_ram = 0;
        if (a[12]) begin
            if (is_rd && m_src[r] == 1) begin ef = 4'b1001; use_rom = 1; end
            if (is_rd && m_src[r] == 2) begin ef = 4'b0101; use_ram = 1; end
            if (!is_rd && m_src[r] == 3) begin ef = 4'b0010; use_ram = 1; end
        end
        af = {rom_oe, ram_oe, ram_we, data_drive};
        exp_addr = 0; act_addr = 0;
        if (use_rom) begin exp_addr = m_bank[r]*1024 + int'(a[9:0]); act_addr = int'(rom_addr); end
        if (use_ram) begin exp_addr = m_bank[r]*512 + int'(a[8:0]); act_addr = int'(ram_addr); end
        n_cmp++;
        if (af !== ef || act_addr != exp_addr) begin
            n_bad++;
            $display("FAIL %s addr=%h rd=%0d flags act=%b exp=%b paddr act=%0d exp=%0d",
                     tag, a, is_rd, af, ef, act_addr, exp_addr);
        end
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic sweep_regions(input int salt, input string tag);
        for (int r = 0; r < 8; r++) begin
            logic [8:0] off;
            off = 9'((salt * 37 + r * 11) % 512);
            probe({1'b1, 3'(r), off}, 1'b1, tag);
            probe({1'b1, 3'(r), off}, 1'b0, tag);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5: boot mapping, top ROM segment on bank 0, rest unmapped
        sweep_regions(1, "R5");
        probe(13'h1FFC, 1'b1, "R5");
        probe(13'h1C00, 1'b1, "R5");

        // R8: window deselected, nothing enabled
        probe(13'h0C10, 1'b1, "R8");
        probe(13'h0E00, 1'b1, "R8");
        probe(13'h0123, 1'b0, "R8");

        // R6: RAM seg 1 hides upper half of ROM seg 0 and 2
        bus_write(13'h003F, 8'h05);          // ROM seg0 bank5
        bus_write(13'h003F, 8'h4A);          // ROM seg2 bank10
        bus_write(13'h003F, 8'hA3);          // RAM seg1 bank3
        probe(13'h1010, 1'b1, "R6");         // ROM seg0 lower half
        probe(13'h1210, 1'b1, "R6");         // RAM read
        probe(13'h1A10, 1'b0, "R6");         // RAM write
        probe(13'h1810, 1'b1, "R6");         // ROM seg2 lower half
        probe(13'h1A10, 1'b1, "R7");         // read of write window
        probe(13'h1210, 1'b0, "R7");         // write to read window
        probe(13'h1010, 1'b0, "R7");         // write to ROM
        bus_write(13'h003F, 8'h07);          // ROM seg0 back, bank7
        probe(13'h1210, 1'b1, "R6");
        probe(13'h1A10, 1'b0, "R6");         // seg2 upper still RAM write

        // R1: mirrors and other offsets do not switch
        bus_write(13'h103F, 8'h9F);
        bus_write(13'h007F, 8'h1F);
        bus_write(13'h0E3F, 8'hE1);
        bus_write(13'h013F, 8'h61);
        sweep_regions(2, "R1");

        // R2, R3, R4: every control byte, then every region both ways
        for (int b = 0; b < 256; b++) begin
            bus_write(13'h003F, 8'(b));
            sweep_regions(b, (b >= 128) ? "R4" : "R3");
        end
        sweep_regions(7, "R2");

        // R5 again after a second reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        sweep_regions(3, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule